// File: doc/BRIEF.md
# I2S Master Audio Clock Generator

This block derives every clock an I2S master transmitter needs from one fast kernel clock. A programmable linear divider produces an intermediate clock at the kernel rate divided by `2*DIV + ODD`. The odd-extension bit allows odd ratios, which gives finer rate steps. The intermediate clock drives one of two paths:

- **Master-clock output enabled.** The intermediate clock leaves the block as the master clock. The bit clock is derived from it by a further divide of 8 (16-bit channel slots) or 4 (32-bit slots). The master clock therefore always runs at 256 times the sample rate.
- **Master-clock output disabled.** The intermediate clock is itself the bit clock.

A word-select output marks the left channel (low) and the right channel (high). A one-cycle frame pulse marks the start of every left-channel slot.

All outputs are registered levels in the kernel-clock domain, so downstream logic can treat them as clock enables. The divider, slot width and master-clock choice are taken from plain configuration inputs while the enable is low. They are frozen while the block runs.

Top module: `i2s_clkgen`

## Requirements
- R1: With the master clock off, the bit clock period is `2*DIV+ODD` kernel cycles.
- R2: For an odd ratio the bit clock is high for DIV+1 kernel cycles and low for DIV cycles. For an even ratio it is high and low for DIV cycles each.
- R3: A DIV value of 0 or 1 gives a ratio of 2 (one cycle high, one cycle low), and ODD is then ignored.
- R4: With the master clock off, the frame period is 32 ratios for 16-bit slots (`wide_i`=0) or 64 ratios for 32-bit slots (`wide_i`=1). In this mode `mck_o` stays low.
- R5: With the master clock on, `mck_o` follows the divided clock. The bit clock is `mck_o` divided by 8 (16-bit slots) or 4 (32-bit slots) at 50% duty. The frame period is 256 ratios for either slot width.
- R6: `ws_o` changes only in the cycle in which `bck_o` falls. It is low for the left slot and high for the right slot, and it toggles twice per frame.
- R7: `frm_o` is a one-cycle pulse raised as `ws_o` returns low. Consecutive pulses are exactly one frame period apart.
- R8: The configuration inputs are sampled only while `en_i` is low. Changing them while `en_i` is high has no effect on the output rates.
- R9: One clock edge after `en_i` falls, all outputs are low and every counter is cleared. At the first edge after `en_i` rises, `bck_o` (and `mck_o`, if enabled) goes high.
- R10: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; configuration is captured while low |
| div_i | input | 8 | Integer divider field DIV |
| odd_i | input | 1 | Odd-extension bit ODD |
| mck_en_i | input | 1 | Enable the master-clock output path |
| wide_i | input | 1 | Slot width select: 0 = 16-bit, 1 = 32-bit |
| mck_o | output | 1 | Master clock (256 x sample rate), low when disabled |
| bck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, low = left channel |
| frm_o | output | 1 | One-cycle pulse at each left-slot start |

## Verification
Each internal counter has a visible signature at the ports:
- **Divider phase counter.** If it runs past its wrap value or resets on the wrong phase, one bit-clock high or low run of the wrong length appears. That shows within a single bit period.
- **Master-clock sub-divider.** A fault here shows as the wrong bit-clock run length within one bit period.
- **Bit counter.** An off-by-one count moves a word-select edge. This changes the frame-pulse spacing, which is visible within one frame.
- **Word-select register.** A stale value makes a word-select edge coincide with a rising bit-clock edge, which the bench catches on that very cycle.
- **Configuration latch.** If it leaks while the block is enabled, the next measured frame period is wrong.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;

  parameter int unsigned CFG_DIV_W = 8;

  typedef enum logic {
    SLOT_16 = 1'b0,
    SLOT_32 = 1'b1
  } slot_e;

  typedef struct packed {
    logic [CFG_DIV_W-1:0] div;
    logic                 odd;
    logic                 mck_en;
    slot_e                slot;
  } clk_cfg_t;

endpackage

// File: rtl/i2s_cfg_hold.sv
module i2s_cfg_hold
  import i2s_clk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  clk_cfg_t cfg_i,
  output clk_cfg_t cfg_o
);

  clk_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (!en_i) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(cfg_q));

endmodule

// File: rtl/i2s_lin_div.sv
module i2s_lin_div #(
  parameter int unsigned DIV_W = i2s_clk_pkg::CFG_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  output logic             dclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  localparam int unsigned CNT_W = DIV_W + 1;

  logic             bad_div;
  logic [CNT_W-1:0] ratio, hi_len, last;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             dclk_d, dclk_q;

  always_comb begin
    bad_div = (div_i < DIV_W'(2));
    ratio   = bad_div ? CNT_W'(2) : {div_i, odd_i};
    hi_len  = bad_div ? CNT_W'(1) : (CNT_W'(div_i) + CNT_W'(odd_i));
    last    = ratio - CNT_W'(1);
  end

  always_comb begin
    cnt_d  = '0;
    dclk_d = 1'b0;
    if (run_i) begin
      cnt_d  = (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
      dclk_d = (cnt_q < hi_len);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dclk_q <= dclk_d;
    end
  end

  assign dclk_o = dclk_q;
  assign rise_o = run_i && (cnt_q == '0);
  assign fall_o = run_i && (cnt_q == hi_len);

  // R1
  div_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);

  // R9
  div_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!dclk_q && cnt_q == '0));

endmodule

// File: rtl/i2s_bck_gen.sv
module i2s_bck_gen #(
  parameter int unsigned MCK_DIV_NARROW = 8,
  parameter int unsigned MCK_DIV_WIDE   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mck_en_i,
  input  logic wide_i,
  input  logic dclk_i,
  input  logic drise_i,
  input  logic dfall_i,
  output logic mck_o,
  output logic bck_o,
  output logic bck_fall_o
);

  localparam int unsigned SUB_W = $clog2(MCK_DIV_NARROW);

  logic [SUB_W-1:0] sub_last, sub_half;
  logic [SUB_W-1:0] sub_d, sub_q;
  logic             sbck_d, sbck_q;
  logic             sub_tick;

  always_comb begin
    sub_last = wide_i ? SUB_W'(MCK_DIV_WIDE - 1)   : SUB_W'(MCK_DIV_NARROW - 1);
    sub_half = wide_i ? SUB_W'(MCK_DIV_WIDE / 2)   : SUB_W'(MCK_DIV_NARROW / 2);
    sub_tick = run_i && mck_en_i && drise_i;
  end

  always_comb begin
    sub_d  = sub_q;
    sbck_d = sbck_q;
    if (!run_i) begin
      sub_d  = '0;
      sbck_d = 1'b0;
    end else if (sub_tick) begin
      sub_d  = (sub_q == sub_last) ? '0 : sub_q + SUB_W'(1);
      sbck_d = (sub_q < sub_half);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      sbck_q <= 1'b0;
    end else begin
      sub_q  <= sub_d;
      sbck_q <= sbck_d;
    end
  end

  assign mck_o      = mck_en_i & dclk_i;
  assign bck_o      = mck_en_i ? sbck_q : dclk_i;
  assign bck_fall_o = mck_en_i ? (sub_tick && (sub_q == sub_half)) : dfall_i;

  // R5
  sub_bck_on_mck_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mck_en_i && run_i && $past(run_i) && !$stable(sbck_q)) |-> $past(drise_i));

endmodule

// File: rtl/i2s_ws_gen.sv
module i2s_ws_gen #(
  parameter int unsigned SLOT_NARROW = 16,
  parameter int unsigned SLOT_WIDE   = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wide_i,
  input  logic bck_fall_i,
  output logic ws_o,
  output logic frm_o
);

  localparam int unsigned BIT_W = $clog2(SLOT_WIDE);

  logic [BIT_W-1:0] bit_last;
  logic [BIT_W-1:0] bit_d, bit_q;
  logic             ws_d, ws_q;
  logic             frm_d, frm_q;
  logic             slot_end;

  always_comb begin
    bit_last = wide_i ? BIT_W'(SLOT_WIDE - 1) : BIT_W'(SLOT_NARROW - 1);
    slot_end = bck_fall_i && (bit_q == bit_last);
  end

  always_comb begin
    bit_d = bit_q;
    ws_d  = ws_q;
    frm_d = 1'b0;
    if (!run_i) begin
      bit_d = '0;
      ws_d  = 1'b0;
    end else if (bck_fall_i) begin
      if (slot_end) begin
        bit_d = '0;
        ws_d  = ~ws_q;
        frm_d = ws_q;
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      ws_q  <= 1'b0;
      frm_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      ws_q  <= ws_d;
      frm_q <= frm_d;
    end
  end

  assign ws_o  = ws_q;
  assign frm_o = frm_q;

  // R6
  ws_on_bck_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(ws_q)) |-> $past(bck_fall_i));

  // R7
  frm_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q |-> !ws_q);

  // R7
  frm_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q |=> !frm_q);

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clk_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [CFG_DIV_W-1:0] div_i,
  input  logic                 odd_i,
  input  logic                 mck_en_i,
  input  logic                 wide_i,
  output logic                 mck_o,
  output logic                 bck_o,
  output logic                 ws_o,
  output logic                 frm_o
);

  clk_cfg_t cfg_in, cfg;
  logic     dclk, drise, dfall, bck_fall, wide;

  always_comb begin
    cfg_in.div    = div_i;
    cfg_in.odd    = odd_i;
    cfg_in.mck_en = mck_en_i;
    cfg_in.slot   = wide_i ? SLOT_32 : SLOT_16;
  end

  i2s_cfg_hold u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg)
  );

  assign wide = (cfg.slot == SLOT_32);

  i2s_lin_div #(.DIV_W(CFG_DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .div_i  (cfg.div),
    .odd_i  (cfg.odd),
    .dclk_o (dclk),
    .rise_o (drise),
    .fall_o (dfall)
  );

  i2s_bck_gen u_bck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_i),
    .mck_en_i   (cfg.mck_en),
    .wide_i     (wide),
    .dclk_i     (dclk),
    .drise_i    (drise),
    .dfall_i    (dfall),
    .mck_o      (mck_o),
    .bck_o      (bck_o),
    .bck_fall_o (bck_fall)
  );

  i2s_ws_gen u_ws (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_i),
    .wide_i     (wide),
    .bck_fall_i (bck_fall),
    .ws_o       (ws_o),
    .frm_o      (frm_o)
  );

endmodule

// File: tb/i2s_clkgen_test.sv
module i2s_clkgen_test;

  logic       clk = 1'b0;
  logic       rst_n, en, odd, mck_en, wide;
  logic [7:0] div;
  logic       mck, bck, ws, frm;

  always #10 clk = ~clk;

  i2s_clkgen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .odd_i(odd),
    .mck_en_i(mck_en), .wide_i(wide),
    .mck_o(mck), .bck_o(bck), .ws_o(ws), .frm_o(frm)
  );

  typedef struct packed {
    logic [7:0]  dv;
    logic        od;
    logic        mk;
    logic        wd;
    logic [15:0] per;
    logic [15:0] bhi;
    logic [15:0] blo;
    logic [15:0] mhi;
    logic [15:0] mlo;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'd5,  1'b0, 1'b0, 1'b0, 16'd320,  16'd5,  16'd5,  16'd0, 16'd0},
    '{8'd62, 1'b1, 1'b0, 1'b0, 16'd4000, 16'd63, 16'd62, 16'd0, 16'd0},
    '{8'd2,  1'b0, 1'b1, 1'b0, 16'd1024, 16'd16, 16'd16, 16'd2, 16'd2},
    '{8'd2,  1'b0, 1'b1, 1'b1, 16'd1024, 16'd8,  16'd8,  16'd2, 16'd2},
    '{8'd5,  1'b1, 1'b0, 1'b1, 16'd704,  16'd6,  16'd5,  16'd0, 16'd0},
    '{8'd0,  1'b1, 1'b0, 1'b0, 16'd64,   16'd1,  16'd1,  16'd0, 16'd0},
    '{8'd1,  1'b0, 1'b0, 1'b1, 16'd128,  16'd1,  16'd1,  16'd0, 16'd0},
    '{8'd3,  1'b1, 1'b1, 1'b0, 16'd1792, 16'd28, 16'd28, 16'd4, 16'd3}
  };

  int n_chk = 0;
  int n_bad = 0;
  int per, bhmin, bhmax, blmin, blmax, mhmin, mhmax, mlmin, mlmax;
  int wst, wsbad, mseen;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_frm();
    int lim = 40000;
    while (!frm && lim > 0) begin
      @(negedge clk);
      lim--;
    end
    if (lim == 0) chk("R7 frame pulse timeout", 0, 1);
  endtask

  // Waits for a frame pulse, then measures one full frame up to the next pulse.
  task automatic measure();
    logic pb, pm, pw;
    int   rb, rm;
    bit   fb, fm;
    wait_frm();
    per = 0;
    bhmin = 99999; bhmax = 0; blmin = 99999; blmax = 0;
    mhmin = 99999; mhmax = 0; mlmin = 99999; mlmax = 0;
    wst = 0; wsbad = 0; mseen = 0;
    pb = bck; pm = mck; pw = ws;
    rb = 1; rm = 1; fb = 0; fm = 0;
    do begin
      @(negedge clk);
      per++;
      if (bck != pb) begin
        if (fb) begin
          if (pb) begin
            if (rb < bhmin) bhmin = rb;
            if (rb > bhmax) bhmax = rb;
          end else begin
            if (rb < blmin) blmin = rb;
            if (rb > blmax) blmax = rb;
          end
        end
        fb = 1; rb = 1;
      end else rb++;
      if (mck != pm) begin
        if (fm) begin
          if (pm) begin
            if (rm < mhmin) mhmin = rm;
            if (rm > mhmax) mhmax = rm;
          end else begin
            if (rm < mlmin) mlmin = rm;
            if (rm > mlmax) mlmax = rm;
          end
        end
        fm = 1; rm = 1;
      end else rm++;
      if (ws != pw) begin
        wst++;
        if (!(pb && !bck)) wsbad++;
      end
      if (mck) mseen = 1;
      pb = bck; pm = mck; pw = ws;
    end while (!frm && per < 40000);
  endtask

  task automatic load(input vec_t v);
    @(negedge clk);
    en = 1'b0;
    div = v.dv; odd = v.od; mck_en = v.mk; wide = v.wd;
    repeat (3) @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; div = 8'd5; odd = 1'b0; mck_en = 1'b0; wide = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 reset outputs", {mck, bck, ws, frm}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      load(VECS[i]);
      measure();
      // R1 R4 R5: frame period
      chk($sformatf("R4/R5 frame period vec %0d", i), per, VECS[i].per);
      // R2 R3: bit clock duty
      chk($sformatf("R2 bck high min vec %0d", i), bhmin, VECS[i].bhi);
      chk($sformatf("R2 bck high max vec %0d", i), bhmax, VECS[i].bhi);
      chk($sformatf("R1 bck low min vec %0d", i), blmin, VECS[i].blo);
      chk($sformatf("R1 bck low max vec %0d", i), blmax, VECS[i].blo);
      // R6: word select edges
      chk($sformatf("R6 ws toggles vec %0d", i), wst, 2);
      chk($sformatf("R6 ws off bck fall vec %0d", i), wsbad, 0);
      if (VECS[i].mk) begin
        // R5: master clock shape
        chk($sformatf("R5 mck high vec %0d", i), mhmax, VECS[i].mhi);
        chk($sformatf("R5 mck low vec %0d", i), mlmin, VECS[i].mlo);
      end else begin
        // R4: master clock held low
        chk($sformatf("R4 mck idle vec %0d", i), mseen, 0);
      end
      // R3: invalid DIV forces ratio 2
      if (VECS[i].dv < 2) chk($sformatf("R3 ratio 2 vec %0d", i), bhmax + blmax, 2);
    end

    // R8: configuration changes while running are ignored
    load(VECS[0]);
    @(negedge clk);
    div = 8'd62; odd = 1'b1; mck_en = 1'b1; wide = 1'b1;
    measure();
    chk("R8 period unchanged", per, 320);
    chk("R8 bck high unchanged", bhmax, 5);
    chk("R8 mck stays off", mseen, 0);

    // R9: disabling clears outputs on the next edge
    while (!(bck && ws)) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9 outputs low after disable", {mck, bck, ws, frm}, 0);

    // R9: first enabled edge raises bck and mck
    div = 8'd3; odd = 1'b0; mck_en = 1'b1; wide = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R9 bck high at first edge", bck, 1);
    chk("R9 mck high at first edge", mck, 1);
    chk("R9 ws left at start", ws, 0);

    finish_run();
  end

endmodule